// File: doc/BRIEF.md
# MAC Learning Forwarding Table

This block is the address table of a small learning bridge. It receives one
request per frame, carrying the destination address (frame bytes 0 to 5), the
source address (frame bytes 6 to 11) and the ingress port number. It answers
with an egress port mask of `NUM_PORTS` bits. That mask is either a single port
taken from the table, or a flood mask that covers every port except the ingress
port.

Each request first learns its source. An unknown source is written into a free
slot, or into the slot that has gone longest without a refresh, along with the
ingress port and the current timestamp. A known source only has its timestamp
refreshed. The destination is looked up in the next cycle. An entry whose age
(now minus last refresh, taken modulo 2^`TS_W`) is greater than the `ttl` input
counts as a miss, and the lookup clears that entry. The free-running timestamp
counts clock cycles from reset.

The request side uses valid/ready. A request is accepted on a rising edge where
`req_valid` and `req_ready` are both high. The response side is valid/ready too:
`rsp_valid` stays high with a stable mask until `rsp_ready` is sampled high. The
table holds one frame at a time, so `req_ready` stays low from acceptance until
the response handshake completes. `ttl` is a plain control input.

Top module: `mac_learn_table`

## Requirements
- R1: After reset `req_ready` is 1 and `rsp_valid` is 0. A request accepted at edge k makes `rsp_valid` high from edge k+2 onward.
- R2: While `rsp_valid` is high and `rsp_ready` is low, the response and its mask hold stable and `req_ready` stays low.
- R3: A destination that is not in the table gives a flood mask: all `NUM_PORTS` bits set except bit `req_port`.
- R4: A destination with its group bit set (`req_dst[40]`, bit 0 of byte 0, which is `req_dst[47:40]`) or equal to all ones gives the flood mask, even if that address was learned as a source.
- R5: A destination that is learned and still valid gives a one-hot mask with bit p set, where p is the port stored for it. This holds even when p equals the ingress port.
- R6: A frame from a source already in the table (not expired) refreshes its timestamp but does not change its stored port.
- R7: A frame's source is learned before its destination is looked up. A frame with source equal to destination and `ttl` of 1 or more forwards to its own ingress port.
- R8: The lookup runs one cycle after the learning edge. An entry whose age is greater than `ttl` is a miss. With `ttl`=0 a frame with source equal to destination floods. A stale entry at a large distance also floods, while a fresh one hits.
- R9: An entry that misses because it expired is cleared. A later lookup still floods after `ttl` is raised again.
- R10: When the table is full, a new source replaces the entry refreshed longest ago. Entries refreshed more recently stay valid. Invalid slots are used before any valid slot is replaced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ttl | input | TS_W | Age limit in cycles |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request can be accepted |
| req_dst | input | 48 | Destination address, byte 0 in bits 47:40 |
| req_src | input | 48 | Source address |
| req_port | input | PW | Ingress port number |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response consumed |
| rsp_mask | output | NUM_PORTS | Egress port mask |

## Verification
Learning and lookup meet within one frame when source and destination are equal. In that case the entry written at the accepting edge is the one the lookup sees one cycle later. The test sends such frames with `ttl` set to 1 and then to 0. The first must come back one-hot on the ingress port and the second as a flood. A follow-up lookup after `ttl` is raised again confirms that the expired entry was cleared rather than skipped.

// File: rtl/mlt_pkg.sv
package mlt_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_LOOK, ST_RESP} mlt_state_e;
endpackage

// File: rtl/mlt_timestamp.sv
module mlt_timestamp #(
  parameter int TS_W = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  output logic [TS_W-1:0] now
);
  always_ff @(posedge clk) begin
    if (!rst_n) now <= '0;
    else        now <= now + 1'b1;
  end
endmodule

// File: rtl/mlt_search.sv
module mlt_search #(
  parameter int DEPTH = 8,
  parameter int KEY_W = 48,
  parameter int TS_W  = 32,
  parameter int IW    = 3
) (
  input  logic [DEPTH-1:0]            vld,
  input  logic [DEPTH-1:0][KEY_W-1:0] keys,
  input  logic [DEPTH-1:0][TS_W-1:0]  stamps,
  input  logic [KEY_W-1:0]            key,
  input  logic [TS_W-1:0]             now,
  input  logic [TS_W-1:0]             ttl,
  output logic                        hit,
  output logic [IW-1:0]               idx,
  output logic                        expired
);
  logic [DEPTH-1:0] match;
  logic [DEPTH-1:0] stale;

  for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
    logic [TS_W-1:0] age;
    assign age      = now - stamps[i];
    assign match[i] = vld[i] && (keys[i] == key);
    assign stale[i] = age > ttl;
  end

  // lowest matching slot wins; duplicates are never written
  always_comb begin
    hit     = 1'b0;
    idx     = '0;
    expired = 1'b0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (match[i]) begin
        hit     = 1'b1;
        idx     = IW'(i);
        expired = stale[i];
      end
    end
  end
endmodule

// File: rtl/mlt_victim.sv
module mlt_victim #(
  parameter int DEPTH = 8,
  parameter int TS_W  = 32,
  parameter int IW    = 3
) (
  input  logic [DEPTH-1:0]           vld,
  input  logic [DEPTH-1:0][TS_W-1:0] stamps,
  input  logic [TS_W-1:0]            now,
  output logic [IW-1:0]              idx
);
  logic [DEPTH-1:0][TS_W-1:0] age;
  logic                       found;
  logic [TS_W-1:0]            best;

  for (genvar i = 0; i < DEPTH; i++) begin : g_age
    assign age[i] = now - stamps[i];
  end

  // first free slot; otherwise the oldest refresh (an expired entry is
  // always at least as old as any live one, so it is taken first)
  always_comb begin
    idx   = '0;
    found = 1'b0;
    best  = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (!found && !vld[i]) begin
        found = 1'b1;
        idx   = IW'(i);
      end
    end
    if (!found) begin
      for (int i = 0; i < DEPTH; i++) begin
        if (age[i] > best) begin
          best = age[i];
          idx  = IW'(i);
        end
      end
    end
  end
endmodule

// File: rtl/mac_learn_table.sv
module mac_learn_table #(
  parameter int NUM_PORTS = 4,
  parameter int DEPTH     = 8,
  parameter int TS_W      = 32
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic [TS_W-1:0]                   ttl,
  input  logic                              req_valid,
  output logic                              req_ready,
  input  logic [47:0]                       req_dst,
  input  logic [47:0]                       req_src,
  input  logic [((NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1)-1:0] req_port,
  output logic                              rsp_valid,
  input  logic                              rsp_ready,
  output logic [NUM_PORTS-1:0]              rsp_mask
);
  import mlt_pkg::*;

  localparam int PW = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1;
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [TS_W-1:0]             now;
  logic [DEPTH-1:0]            e_vld;
  logic [DEPTH-1:0][47:0]      e_mac;
  logic [DEPTH-1:0][PW-1:0]    e_port;
  logic [DEPTH-1:0][TS_W-1:0]  e_ts;

  mlt_state_e                  state;
  logic [47:0]                 q_dst;
  logic [PW-1:0]               q_port;

  logic                        s_hit, s_exp, d_hit, d_exp;
  logic [IW-1:0]               s_idx, d_idx, v_idx, wr_idx;
  logic                        accept, wr_port, group;
  logic [NUM_PORTS-1:0]        flood, hit_mask;

  mlt_timestamp #(.TS_W(TS_W)) u_ts (
    .clk(clk), .rst_n(rst_n), .now(now)
  );

  mlt_search #(.DEPTH(DEPTH), .KEY_W(48), .TS_W(TS_W), .IW(IW)) u_src (
    .vld(e_vld), .keys(e_mac), .stamps(e_ts), .key(req_src),
    .now(now), .ttl(ttl), .hit(s_hit), .idx(s_idx), .expired(s_exp)
  );

  mlt_search #(.DEPTH(DEPTH), .KEY_W(48), .TS_W(TS_W), .IW(IW)) u_dst (
    .vld(e_vld), .keys(e_mac), .stamps(e_ts), .key(q_dst),
    .now(now), .ttl(ttl), .hit(d_hit), .idx(d_idx), .expired(d_exp)
  );

  mlt_victim #(.DEPTH(DEPTH), .TS_W(TS_W), .IW(IW)) u_vic (
    .vld(e_vld), .stamps(e_ts), .now(now), .idx(v_idx)
  );

  assign req_ready = (state == ST_IDLE);
  assign rsp_valid = (state == ST_RESP);
  assign accept    = req_valid && req_ready;

  // a known source keeps its port unless its entry has already aged out
  assign wr_idx  = s_hit ? s_idx : v_idx;
  assign wr_port = !s_hit || s_exp;
  assign group   = q_dst[40] || (&q_dst);

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_mask
    assign flood[p]    = (q_port != PW'(p));
    assign hit_mask[p] = (e_port[d_idx] == PW'(p));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      q_dst    <= '0;
      q_port   <= '0;
      rsp_mask <= '0;
      e_vld    <= '0;
      e_mac    <= '0;
      e_port   <= '0;
      e_ts     <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (accept) begin
            q_dst          <= req_dst;
            q_port         <= req_port;
            e_vld[wr_idx]  <= 1'b1;
            e_mac[wr_idx]  <= req_src;
            e_ts[wr_idx]   <= now;
            if (wr_port) e_port[wr_idx] <= req_port;
            state          <= ST_LOOK;
          end
        end
        ST_LOOK: begin
          if (!group && d_hit && !d_exp) rsp_mask <= hit_mask;
          else                           rsp_mask <= flood;
          if (d_hit && d_exp) e_vld[d_idx] <= 1'b0;
          state <= ST_RESP;
        end
        ST_RESP: begin
          if (rsp_ready) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mlt_chk.sv
module mlt_chk #(
  parameter int NUM_PORTS = 4,
  parameter int PW        = 2
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 req_valid,
  input logic                 req_ready,
  input logic                 req_grp,
  input logic [PW-1:0]        req_port,
  input logic                 rsp_valid,
  input logic                 rsp_ready,
  input logic [NUM_PORTS-1:0] rsp_mask
);
  logic [PW-1:0]        cap_port;
  logic                 cap_grp;
  logic [NUM_PORTS-1:0] exp_flood;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cap_port <= '0;
      cap_grp  <= 1'b0;
    end else if (req_valid && req_ready) begin
      cap_port <= req_port;
      cap_grp  <= req_grp;
    end
  end

  always_comb begin
    for (int p = 0; p < NUM_PORTS; p++) exp_flood[p] = (cap_port != PW'(p));
  end

  assert_latency_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> ##1 rsp_valid);

  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_mask)));

  assert_no_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready);

  assert_shape_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> ($countones(rsp_mask) == 1 || rsp_mask == exp_flood));

  assert_group_flood_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && cap_grp) |-> (rsp_mask == exp_flood));
endmodule

bind mac_learn_table mlt_chk #(.NUM_PORTS(NUM_PORTS), .PW(PW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_grp(req_dst[40] | (&req_dst)), .req_port(req_port),
  .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_mask(rsp_mask)
);

// File: tb/mac_learn_table_tb.sv
module mac_learn_table_tb;
  localparam int NP = 4;
  localparam logic [47:0] BCAST = 48'hFFFF_FFFF_FFFF;
  localparam logic [47:0] MCAST = 48'h0100_5E00_0001;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] ttl = 32'd1000;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [47:0] req_dst = '0;
  logic [47:0] req_src = '0;
  logic [1:0]  req_port = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [NP-1:0] rsp_mask;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  bit seen = 1'b0;

  logic [NP-1:0] q_mask[$];
  int            q_cyc[$];
  string         q_tag[$];

  mac_learn_table #(.NUM_PORTS(NP), .DEPTH(8), .TS_W(32)) u_dut (
    .clk(clk), .rst_n(rst_n), .ttl(ttl), .req_valid(req_valid),
    .req_ready(req_ready), .req_dst(req_dst), .req_src(req_src),
    .req_port(req_port), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_mask(rsp_mask)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [47:0] mac(input int n);
    return {8'h02, 32'h0, 8'(n)};
  endfunction

  function automatic logic [NP-1:0] flood(input int p);
    return {NP{1'b1}} & ~(NP'(1) << p);
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [47:0] dst, input logic [47:0] src,
                      input int port, input logic [NP-1:0] exp_mask,
                      input string tag);
    @(negedge clk);
    req_dst   = dst;
    req_src   = src;
    req_port  = 2'(port);
    req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    q_mask.push_back(exp_mask);
    q_cyc.push_back(cyc + 2);
    q_tag.push_back(tag);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic drain();
    while (q_mask.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (rsp_valid && !seen) begin
        seen = 1'b1;
        if (q_mask.size() == 0) check(1'b0, "R1 unexpected response", 1, 0);
        else check(cyc == q_cyc[0], {q_tag[0], " latency R1"}, cyc, q_cyc[0]);
      end
      if (rsp_valid && rsp_ready && q_mask.size() != 0) begin
        check(rsp_mask == q_mask[0], q_tag[0], int'(rsp_mask), int'(q_mask[0]));
        void'(q_mask.pop_front());
        void'(q_cyc.pop_front());
        void'(q_tag.pop_front());
        seen = 1'b0;
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    do_reset();
    @(negedge clk);
    check(req_ready == 1'b1, "R1 reset req_ready", int'(req_ready), 1);
    check(rsp_valid == 1'b0, "R1 reset rsp_valid", int'(rsp_valid), 0);

    ttl = 32'd1000;
    send(BCAST,  mac(1), 1, flood(1), "R4 broadcast");
    send(mac(9), mac(2), 2, flood(2), "R3 unknown dst");
    send(mac(1), mac(3), 0, 4'b0010, "R5 hit");
    send(mac(1), mac(4), 1, 4'b0010, "R5 hit ingress port");
    send(mac(1), mac(1), 3, 4'b0010, "R6 port not rewritten");
    send(mac(1), mac(2), 2, 4'b0010, "R6 port kept");
    send(mac(2), MCAST,  0, 4'b0100, "R5 hit port2");
    send(MCAST,  mac(3), 1, flood(1), "R4 group dst learned");
    drain();

    rsp_ready = 1'b0;
    send(mac(3), mac(2), 2, 4'b0001, "R2 held response");
    repeat (2) @(negedge clk);
    for (int i = 0; i < 5; i++) begin
      check(rsp_valid == 1'b1, "R2 valid held", int'(rsp_valid), 1);
      check(req_ready == 1'b0, "R2 no accept", int'(req_ready), 0);
      @(negedge clk);
    end
    rsp_ready = 1'b1;
    drain();

    ttl = 32'd1;
    send(mac(20), mac(20), 3, 4'b1000, "R7 learn then lookup");
    drain();
    ttl = 32'd0;
    send(mac(21), mac(21), 2, flood(2), "R8 age1 over ttl0");
    drain();
    ttl = 32'd1000;
    send(mac(21), mac(3), 0, flood(0), "R9 cleared entry");
    drain();

    ttl = 32'd20;
    send(mac(30), mac(31), 1, flood(1), "R3 unknown dst");
    send(mac(31), mac(3), 0, 4'b0010, "R8 fresh hit");
    drain();
    repeat (40) @(negedge clk);
    send(mac(31), mac(3), 0, flood(0), "R8 stale miss");
    drain();

    do_reset();
    ttl = 32'd1000;
    for (int i = 0; i < 8; i++) send(BCAST, mac(40 + i), i % 4, flood(i % 4), "R10 fill");
    send(BCAST, mac(40), 0, flood(0), "R10 refresh");
    send(BCAST, mac(48), 3, flood(3), "R10 new source");
    send(mac(41), mac(40), 0, flood(0), "R10 oldest evicted");
    send(mac(40), mac(40), 0, 4'b0001, "R10 refreshed kept");
    send(mac(48), mac(40), 0, 4'b1000, "R10 new entry");
    send(mac(42), mac(40), 0, 4'b0100, "R10 others kept");
    send(mac(47), mac(40), 0, 4'b1000, "R10 last fill kept");
    drain();

    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule